// File: doc/BRIEF.md
# Sequential Block Transfer Window Sequencer

This block runs a block transfer that is fixed in advance through one window of a peripheral bus. When the window opens, the host gives four values: a starting displacement into the target object, a count field, a direction, and the highest valid displacement of the object. The sequencer checks these values once, at that point. After the window opens, every reference that the address decoder reports as falling inside the window's subrange moves the next byte or double-byte of the block. The exact bus address has no effect. The object displacement comes from an internal counter, so a bus master can sweep a range of addresses or hit one address over and over. Both give the same sequence of displacements.

The block does not buffer data and does not access memory. For each accepted reference it emits a transfer strobe with the displacement and width to use. It also answers each reference with a positive or a negative acknowledge. It keeps a two-bit transfer status and pulses an interrupt request on every event the host must see: a refused open, normal completion, forced termination, a fault, or a refused close. A terminated window stays in place until the host closes it. Any reference that arrives in the meantime sends the window into a sticky error state, and from then on every reference gets a negative acknowledge.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset the window is closed (`winOpen`=0), `status`=2'b00, and `refAck`, `refNak`, `xferStrobe`, `irq` and `closeRefused` are all 0.
- R2: An open request on a closed window succeeds when `openBase`+`openCount` <= `openLimit`. The window then opens with `status`=2'b00 (active) and no interrupt. If the sum is larger, the window stays closed, `status` becomes 2'b11 (faulted) and `irq` pulses.
- R3: In the active state, a reference whose `refWrite` equals the opened direction gets `refAck` and one `xferStrobe`. `xferDisp` equals the base plus the number of bytes already moved, and `xferWide` repeats `refWide`. A byte reference advances the displacement by 1 and a double-byte reference by 2, independent of any bus address.
- R4: The count field holds one less than the number of bytes to move. The reference that takes the remaining count below zero is acknowledged and strobed. It also sets `status`=2'b01 (done), pulses `irq` and terminates the window.
- R5: An active reference with the wrong direction, or a double-byte reference when one byte remains, gets `refNak` with no strobe. It sets `status`=2'b11, pulses `irq` and enters the error state.
- R6: In the active state, `forceTerm` or any bit of `closeMsg` terminates the transfer with `status`=2'b10 (forced) and an `irq` pulse. A reference in the same cycle gets `refNak` and no strobe. Termination takes priority over the reference.
- R7: A reference to a terminated window gets `refNak`, sets `status`=2'b11, pulses `irq` once and enters the error state. Later references in the error state get `refNak` with no strobe and no `irq`.
- R8: `closeReq` on an active window, when no termination arrives in the same cycle, pulses `closeRefused` and `irq`. The window stays open and the transfer goes on from where it was.
- R9: `closeReq` on a terminated or errored window closes it (`winOpen`=0) and leaves `status` unchanged. A reference in the same cycle is ignored, and a new open is then accepted.
- R10: References to a closed window get neither acknowledge. An open request on a window that is already open is ignored, and the transfer sequence is unchanged.
- R11: All outputs are registered. The response to inputs sampled at a clock edge appears after that edge, and none appears in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| openReq | input | 1 | Request to open the window with the attributes below |
| openBase | input | DISP_W | Starting displacement in the object |
| openCount | input | CNT_W | Number of bytes to move, minus one |
| openLimit | input | DISP_W | Highest valid displacement of the object |
| openWrite | input | 1 | Transfer direction, 1 = write, 0 = read |
| refValid | input | 1 | A bus reference falls in the window subrange |
| refWrite | input | 1 | Direction of the bus reference |
| refWide | input | 1 | Reference is a double-byte |
| forceTerm | input | 1 | Host command to force termination |
| closeMsg | input | 3 | Close/suspend messages; any bit forces termination |
| closeReq | input | 1 | Host request to close the window |
| refAck | output | 1 | Positive acknowledge of a reference |
| refNak | output | 1 | Negative acknowledge, no data moved |
| xferStrobe | output | 1 | One data move to perform |
| xferDisp | output | DISP_W | Object displacement of that move |
| xferWide | output | 1 | That move is a double-byte |
| status | output | 2 | 00 active, 01 done, 10 forced, 11 faulted |
| irq | output | 1 | Interrupt request pulse |
| closeRefused | output | 1 | Close attempted without prior termination |
| winOpen | output | 1 | Window is open (active, terminated or errored) |

## Verification
The hardest case to reach from the ports is the end of a block, where the remaining count is exactly zero or one. There, a double-byte reference either completes the block or faults it, and the next reference runs into a terminated window. Random stimulus uses short byte counts and mostly double-byte references, so transfers often land on this boundary. Directed sequences also drive single-byte blocks, two-byte blocks taken in one double-byte, and an odd count finished with a double-byte. Each of these is followed by references to the terminated window, so the error state is reached both with and without an interrupt.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  typedef enum logic [1:0] {
    ST_CLOSED = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_TERM   = 2'd2,
    ST_ERROR  = 2'd3
  } winState_t;

  localparam logic [1:0] STAT_ACTIVE = 2'b00;
  localparam logic [1:0] STAT_DONE   = 2'b01;
  localparam logic [1:0] STAT_FORCED = 2'b10;
  localparam logic [1:0] STAT_FAULT  = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture open attributes
    logic advance;  // move one item
    logic wide;     // item is a double-byte
  } dpCtl_t;

endpackage

// File: rtl/blk_xfer_dp.sv
module blk_xfer_dp
  import blk_xfer_pkg::*;
#(
  parameter int DISP_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic [DISP_W-1:0] openBase,
  input  logic [CNT_W-1:0]  openCount,
  input  logic [DISP_W-1:0] openLimit,
  output logic              openOk,
  output logic              remZero,
  output logic              remOne,
  output logic              xferStrobe,
  output logic [DISP_W-1:0] xferDisp,
  output logic              xferWide
);

  localparam int SUM_W = ((DISP_W > CNT_W) ? DISP_W : CNT_W) + 1;

  logic [SUM_W-1:0]  lastByte;
  logic [DISP_W-1:0] dispQ;
  logic [CNT_W-1:0]  remQ;
  logic [1:0]        stepSz;

  // open-time bounds check on the refinement end
  assign lastByte = SUM_W'(openBase) + SUM_W'(openCount);
  assign openOk   = lastByte <= SUM_W'(openLimit);

  assign stepSz  = ctl.wide ? 2'd2 : 2'd1;
  assign remZero = (remQ == '0);
  assign remOne  = (remQ == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dispQ      <= '0;
      remQ       <= '0;
      xferStrobe <= 1'b0;
      xferDisp   <= '0;
      xferWide   <= 1'b0;
    end else begin
      xferStrobe <= ctl.advance;
      if (ctl.load) begin
        dispQ <= openBase;
        remQ  <= openCount;
      end else if (ctl.advance) begin
        dispQ    <= dispQ + DISP_W'(stepSz);
        remQ     <= remQ - CNT_W'(stepSz);
        xferDisp <= dispQ;
        xferWide <= ctl.wide;
      end
    end
  end

  // a double-byte may never be issued with a single byte left (R5)
  p_rem_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.advance && ctl.wide) |-> !remZero);

  // load and advance are never requested together
  p_load_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.load && ctl.advance));

endmodule

// File: rtl/blk_xfer_ctl.sv
module blk_xfer_ctl
  import blk_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       openReq,
  input  logic       openWrite,
  input  logic       openOk,
  input  logic       refValid,
  input  logic       refWrite,
  input  logic       refWide,
  input  logic       forceTerm,
  input  logic [2:0] closeMsg,
  input  logic       closeReq,
  input  logic       remZero,
  input  logic       remOne,
  output dpCtl_t     dpc,
  output logic       refAck,
  output logic       refNak,
  output logic       irq,
  output logic [1:0] status,
  output logic       closeRefused,
  output logic       winOpen
);

  winState_t  state, stateN;
  logic [1:0] statusN;
  logic       dirQ;
  logic       ackN, nakN, irqN, crN;
  logic       terminate, lastItem, badRef;

  assign terminate = forceTerm || (|closeMsg);
  assign lastItem  = refWide ? remOne : remZero;
  assign badRef    = (refWrite != dirQ) || (refWide && remZero);

  always_comb begin
    stateN  = state;
    statusN = status;
    ackN    = 1'b0;
    nakN    = 1'b0;
    irqN    = 1'b0;
    crN     = 1'b0;
    dpc     = '0;
    unique case (state)
      ST_CLOSED: begin
        if (openReq) begin
          if (openOk) begin
            stateN   = ST_ACTIVE;
            statusN  = STAT_ACTIVE;
            dpc.load = 1'b1;
          end else begin
            statusN = STAT_FAULT;
            irqN    = 1'b1;
          end
        end
      end
      ST_ACTIVE: begin
        if (terminate) begin
          stateN  = ST_TERM;
          statusN = STAT_FORCED;
          irqN    = 1'b1;
          nakN    = refValid;
        end else if (refValid) begin
          if (badRef) begin
            nakN    = 1'b1;
            statusN = STAT_FAULT;
            irqN    = 1'b1;
            stateN  = ST_ERROR;
          end else begin
            ackN        = 1'b1;
            dpc.advance = 1'b1;
            dpc.wide    = refWide;
            if (lastItem) begin
              stateN  = ST_TERM;
              statusN = STAT_DONE;
              irqN    = 1'b1;
            end
          end
        end
        if (closeReq && !terminate) begin
          crN  = 1'b1;
          irqN = 1'b1;
        end
      end
      ST_TERM: begin
        if (closeReq) begin
          stateN = ST_CLOSED;
        end else if (refValid) begin
          nakN    = 1'b1;
          statusN = STAT_FAULT;
          irqN    = 1'b1;
          stateN  = ST_ERROR;
        end
      end
      ST_ERROR: begin
        if (closeReq) stateN = ST_CLOSED;
        else          nakN   = refValid;
      end
      default: stateN = ST_CLOSED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_CLOSED;
      status       <= STAT_ACTIVE;
      dirQ         <= 1'b0;
      refAck       <= 1'b0;
      refNak       <= 1'b0;
      irq          <= 1'b0;
      closeRefused <= 1'b0;
    end else begin
      state        <= stateN;
      status       <= statusN;
      refAck       <= ackN;
      refNak       <= nakN;
      irq          <= irqN;
      closeRefused <= crN;
      if (dpc.load) dirQ <= openWrite;
    end
  end

  assign winOpen = (state != ST_CLOSED);

  p_ack_nak_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(refAck && refNak));

  p_closed_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (refValid && state == ST_CLOSED) |=> (!refAck && !refNak));

  p_err_nak_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (refValid && state == ST_ERROR && !closeReq) |=> (refNak && !irq));

  p_refuse_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    closeRefused |-> winOpen);

  p_force_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && forceTerm) |=> (status == STAT_FORCED && irq));

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int DISP_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              openReq,
  input  logic [DISP_W-1:0] openBase,
  input  logic [CNT_W-1:0]  openCount,
  input  logic [DISP_W-1:0] openLimit,
  input  logic              openWrite,
  input  logic              refValid,
  input  logic              refWrite,
  input  logic              refWide,
  input  logic              forceTerm,
  input  logic [2:0]        closeMsg,
  input  logic              closeReq,
  output logic              refAck,
  output logic              refNak,
  output logic              xferStrobe,
  output logic [DISP_W-1:0] xferDisp,
  output logic              xferWide,
  output logic [1:0]        status,
  output logic              irq,
  output logic              closeRefused,
  output logic              winOpen
);

  dpCtl_t dpc;
  logic   openOk, remZero, remOne;

  blk_xfer_ctl ctl_i (
    .clk(clk), .rst_n(rst_n),
    .openReq(openReq), .openWrite(openWrite), .openOk(openOk),
    .refValid(refValid), .refWrite(refWrite), .refWide(refWide),
    .forceTerm(forceTerm), .closeMsg(closeMsg), .closeReq(closeReq),
    .remZero(remZero), .remOne(remOne),
    .dpc(dpc), .refAck(refAck), .refNak(refNak), .irq(irq),
    .status(status), .closeRefused(closeRefused), .winOpen(winOpen)
  );

  blk_xfer_dp #(.DISP_W(DISP_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(dpc),
    .openBase(openBase), .openCount(openCount), .openLimit(openLimit),
    .openOk(openOk), .remZero(remZero), .remOne(remOne),
    .xferStrobe(xferStrobe), .xferDisp(xferDisp), .xferWide(xferWide)
  );

  // a refused reference never moves data (R5)
  p_nak_nodata_r5: assert property (@(posedge clk) disable iff (!rst_n)
    refNak |-> !xferStrobe);

  // every data move is positively acknowledged (R3)
  p_strobe_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xferStrobe |-> refAck);

  // an interrupt always carries a visible cause (R2, R4-R8)
  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != STAT_ACTIVE || closeRefused));

endmodule

// File: tb/blk_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        openReq = 0, openWrite = 0, refValid = 0, refWrite = 0, refWide = 0;
  logic        forceTerm = 0, closeReq = 0;
  logic [2:0]  closeMsg = '0;
  logic [15:0] openBase = '0, openCount = '0, openLimit = '0;
  logic        refAck, refNak, xferStrobe, xferWide, irq, closeRefused, winOpen;
  logic [15:0] xferDisp;
  logic [1:0]  status;

  int errors = 0;
  int checks = 0;
  int mState = 0, mDisp = 0, mRem = 0, mStatus = 0;
  bit mDir = 0;

  always #2.5 clk = ~clk;

  blk_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .openReq(openReq), .openBase(openBase), .openCount(openCount),
    .openLimit(openLimit), .openWrite(openWrite),
    .refValid(refValid), .refWrite(refWrite), .refWide(refWide),
    .forceTerm(forceTerm), .closeMsg(closeMsg), .closeReq(closeReq),
    .refAck(refAck), .refNak(refNak), .xferStrobe(xferStrobe),
    .xferDisp(xferDisp), .xferWide(xferWide), .status(status),
    .irq(irq), .closeRefused(closeRefused), .winOpen(winOpen)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit openFits(int base, int cnt, int lim);
    return (base + cnt) <= lim;
  endfunction

  // one cycle: drive at negedge, model, sample at the following negedge
  task automatic drive(bit op, int base, int cnt, int lim, bit dw,
                       bit rv, bit rw, bit wd, bit fc, bit [2:0] msg, bit cl);
    string tg = "R10";
    bit eAck = 0, eNak = 0, eStr = 0, eWide = 0, eIrq = 0, eCr = 0, term;
    int eDisp = 0, n;
    openReq = op; openBase = 16'(base); openCount = 16'(cnt);
    openLimit = 16'(lim); openWrite = dw; refValid = rv; refWrite = rw;
    refWide = wd; forceTerm = fc; closeMsg = msg; closeReq = cl;
    case (mState)
      0: if (op) begin
           tg = "R2";
           if (openFits(base, cnt, lim)) begin
             mState = 1; mDisp = base; mRem = cnt; mDir = dw; mStatus = 0;
           end else begin
             mStatus = 3; eIrq = 1;
           end
         end
      1: begin
           term = fc || (msg != 0);
           if (term) begin
             mState = 2; mStatus = 2; eIrq = 1; eNak = rv; tg = "R6";
           end else if (rv) begin
             if (rw != mDir || (wd && mRem == 0)) begin
               eNak = 1; mStatus = 3; eIrq = 1; mState = 3; tg = "R5";
             end else begin
               n = wd ? 2 : 1;
               eAck = 1; eStr = 1; eDisp = mDisp; eWide = wd; tg = "R3";
               mDisp = (mDisp + n) & 16'hFFFF;
               if ((wd && mRem == 1) || (!wd && mRem == 0)) begin
                 mState = 2; mStatus = 1; eIrq = 1; tg = "R4";
               end
               mRem -= n;
             end
           end
           if (cl && !term) begin
             eCr = 1; eIrq = 1; tg = "R8";
           end
         end
      default: begin
           if (cl) begin
             mState = 0; tg = "R9";
           end else if (rv) begin
             tg = "R7"; eNak = 1;
             if (mState == 2) begin
               mStatus = 3; eIrq = 1; mState = 3;
             end
           end
         end
    endcase
    @(posedge clk);
    @(negedge clk);
    chk(tg, "refAck", int'(refAck), int'(eAck));
    chk(tg, "refNak", int'(refNak), int'(eNak));
    chk(tg, "xferStrobe", int'(xferStrobe), int'(eStr));
    if (eStr) begin
      chk(tg, "xferDisp", int'(xferDisp), eDisp);
      chk(tg, "xferWide", int'(xferWide), int'(eWide));
    end
    chk(tg, "irq", int'(irq), int'(eIrq));
    chk(tg, "status", int'(status), mStatus);
    chk(tg, "closeRefused", int'(closeRefused), int'(eCr));
    chk(tg, "winOpen", int'(winOpen), int'(mState != 0));
    openReq = 0; refValid = 0; forceTerm = 0; closeMsg = '0; closeReq = 0;
  endtask

  task automatic openW(int base, int cnt, int lim, bit dw);
    drive(1, base, cnt, lim, dw, 0, 0, 0, 0, 3'b0, 0);
  endtask
  task automatic refW(bit rw, bit wd);
    drive(0, 0, 0, 0, 0, 1, rw, wd, 0, 3'b0, 0);
  endtask
  task automatic closeW();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 3'b0, 1);
  endtask
  task automatic forceW(bit [2:0] msg);
    drive(0, 0, 0, 0, 0, 0, 0, 0, msg == 0, msg, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "winOpen", int'(winOpen), 0);
    chk("R1", "status", int'(status), 0);
    chk("R1", "refAck|refNak|irq", int'(refAck | refNak | irq), 0);
    chk("R1", "xferStrobe|closeRefused", int'(xferStrobe | closeRefused), 0);

    // R10 references to closed window, R2 refused open
    refW(0, 0);
    openW(10, 5, 14, 1);
    openW(10, 5, 15, 1);                  // exact fit opens
    // R10 second open ignored; R11 no same-cycle response
    openW(100, 0, 200, 0);
    refValid = 1; refWrite = 1; #1;
    chk("R11", "refAck before edge", int'(refAck), 0);
    refW(1, 1); refW(1, 0);                 // disp 10, 12
    closeW();                               // R8 refused
    refW(1, 1);                             // disp 13, rem 0
    refW(1, 1);                             // R5 double with one left
    refW(1, 0);                             // R7 error naks
    closeW();                               // R9

    // R4 single-byte block, then R7 ref after done
    openW(0, 0, 0, 0);
    refW(0, 0);
    refW(0, 0);
    refW(0, 1);
    closeW();
    // R4 two bytes in one double-byte; R5 wrong direction
    openW(7, 1, 8, 1);
    refW(1, 1);
    closeW();
    openW(7, 3, 20, 1);
    refW(0, 0);
    closeW();
    // R6 each close/suspend message plus host force, ref same cycle
    for (int m = 0; m < 4; m++) begin
      openW(3, 9, 50, 0);
      refW(0, 1);
      drive(0, 0, 0, 0, 0, 1, 0, 0, m == 3, (m == 3) ? 3'b0 : 3'(1 << m), 0);
      refW(0, 0);
      closeW();
    end

    // constrained random transfers
    for (int t = 0; t < 80; t++) begin
      int base = $urandom % 300;
      int cnt = $urandom % 12;
      int lim = ($urandom % 5 == 0 && base + cnt > 0) ? base + cnt - 1
                                                    : base + cnt + $urandom % 8;
      bit dw = $urandom % 2;
      openW(base, cnt, lim, dw);
      for (int c = 0; c < cnt + 6; c++) begin
        int r = $urandom % 100;
        bit rv = r < 80;
        bit rw = (r % 23 == 0) ? !dw : dw;
        bit wd = ($urandom % 100) < 60;
        bit fc = ($urandom % 100) < 2;
        bit [2:0] msg = (($urandom % 100) < 2) ? 3'(1 << ($urandom % 3)) : 3'b0;
        bit cl = ($urandom % 100) < 5;
        drive(0, 0, 0, 0, 0, rv, rw, wd, fc, msg, cl);
      end
      forceW(3'b0);
      closeW();
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule